// File: doc/BRIEF.md
# ISA 8-bit Bus Cycle Sequencer

This block is the system-board engine that runs a single bus cycle to an 8-bit expansion target. It covers memory and I/O space, in both directions. A host asks for a transfer by holding a request together with an address, a direction bit, a space bit and write data. The block then walks the bus through one address BCLK and a run of data BCLKs. When the transfer ends it returns a one-clock completion pulse, the captured read byte and two status flags.

The block runs on a clock at twice the bus-clock rate, so every half-BCLK event lands on a real edge. A free-running phase bit splits each bus clock into a high half and a low half. Every bus-side output comes from a flop clocked by the double-rate clock.

The block samples four target responses:
- a wide-memory indication;
- a wide-I/O indication;
- a zero-wait-state request, which shortens the cycle;
- a channel-ready line, which lengthens it.

A watchdog limits how long channel-ready can hold the cycle open.

Top module: `isa8_cycle_ctl`

## Requirements
- R1: The block accepts a request only at the end of the low half of a bus clock while idle. The address BCLK then follows. `ale_o` is high for exactly the low (second) half of that BCLK. `busclk_o` is high in the first half of every bus clock and low in the second half.
- R2: `baddr_o` takes the request address when `ale_o` rises. It holds that value, unchanged, until the end of the last data clock.
- R3: On a write (`wr_i`=1), `bdata_oe_o` turns on when `ale_o` rises and `bdata_o` then carries the write byte. The enable stays on through idle time until the middle of the next cycle's address BCLK. At that point it turns off if the next cycle is a read.
- R4: Exactly one active-low command strobe is driven low, chosen by `io_i` (1 = I/O space) and `wr_i` (1 = write). It goes low at the middle of data clock 1 and goes high at the end of the last data clock.
- R5: `wide_o` is reported with the completion pulse, and the cycle timing is the same either way. For memory, `wide_o` is set when `mem_wide_n_i` was low both at the end of the address BCLK and at the middle of data clock 1. For I/O, it is set when `io_wide_n_i` was low at the middle of data clock 1.
- R6: `zws_n_i` is sampled low at the middle of data clock 2, 3 or 4. The cycle then ends at the end of that data clock, for a total of 3, 4 or 5 BCLKs. A low sample at the middle of data clock 1 has no effect.
- R7: With no zero-wait-state request, and `rdy_i` high at the middle of data clock 5, the cycle ends at the end of data clock 5. That is six BCLKs in total.
- R8: If `rdy_i` is low at the middle of data clock 5 or of any later data clock, another data clock is added. The cycle ends at the end of the first data clock whose middle sample sees `rdy_i` high. From data clock 5 on, `zws_n_i` has no effect.
- R9: On a read, `bdata_i` is captured at the end of the last data clock. `done_o` pulses for one clock right after that edge, and `rdata_o` already holds the byte. A write cycle leaves `rdata_o` unchanged.
- R10: `rdy_i` may still be low at the middle of data clock `WD_DCLKS`. The cycle then ends at the end of that data clock with `err_o` high together with `done_o`, the command released and `rdata_o` unchanged.
- R11: In reset, all command strobes are high and `ale_o`, `bdata_oe_o`, `done_o`, `err_o` are low. `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock (two edges per bus clock) |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request, held until `done_o` |
| addr_i | input | AW | Transfer address |
| wr_i | input | 1 | 1 = write, 0 = read |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| wdata_i | input | DW | Write byte |
| rdata_o | output | DW | Last captured read byte |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Cycle ended by the watchdog (with `done_o`) |
| wide_o | output | 1 | Target reported itself wide (with `done_o`) |
| busclk_o | output | 1 | Bus clock |
| ale_o | output | 1 | Address latch enable |
| baddr_o | output | AW | Latched bus address |
| bdata_o | output | DW | Bus write data |
| bdata_oe_o | output | 1 | Bus write-data enable |
| bdata_i | input | DW | Bus read data |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| mem_wide_n_i | input | 1 | Wide-memory indication, active low |
| io_wide_n_i | input | 1 | Wide-I/O indication, active low |
| zws_n_i | input | 1 | Zero-wait-state request, active low |
| rdy_i | input | 1 | Channel ready |

## Verification
The bench aims at several edges of the cycle, and each catches a distinct class of bug:
- A zero-wait-state pulse at the middle of data clock 1. A sequencer that sampled it one clock early would end the cycle after two BCLKs.
- The same pulse during a channel-ready stretch. A design that let it win would end the stretch too soon.
- Channel-ready rising exactly at data clock `WD_DCLKS`, and again one data clock too late. An off-by-one watchdog either flags a good cycle or lets a hung one run on.
- Read data that is valid only during the final half-clock. A capture one edge early or late returns the inverted byte.
- A wide-memory indication seen only at the first of its two samples. A design that ignored the second sample would report a wide target.

// File: rtl/isa8_pkg.sv
package isa8_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } slot_e;

  // strobe index = {space, direction}: 0 mem rd, 1 mem wr, 2 io rd, 3 io wr
  localparam int NCMD = 4;

  function automatic logic [1:0] cmd_sel(input logic io, input logic wr);
    return {io, wr};
  endfunction
endpackage

// File: rtl/isa8_halfclk.sv
module isa8_halfclk (
  input  logic clk,
  input  logic rst,
  output logic ph_q,
  output logic ph_nxt,
  output logic busclk_o
);
  // ph_q = 0: first (high) half of a bus clock, 1: second (low) half
  assign ph_nxt = ~ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= 1'b0;
      busclk_o <= 1'b1;
    end else begin
      ph_q     <= ph_nxt;
      busclk_o <= ~ph_nxt;
    end
  end

  assert_phase_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    busclk_o |=> !busclk_o);
endmodule

// File: rtl/isa8_seq.sv
module isa8_seq
  import isa8_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int WD_DCLKS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_q,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          io_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          zws_n_i,
  input  logic          rdy_i,
  input  logic          mem_wide_n_i,
  input  logic          io_wide_n_i,
  output slot_e         st_nxt,
  output logic          d1_nxt,
  output logic          fin_edge,
  output logic          wd_q,
  output logic          wide_q,
  output logic [AW-1:0] addr_q,
  output logic          wr_q,
  output logic          io_q,
  output logic [DW-1:0] wdata_q
);
  localparam int CW = $clog2(WD_DCLKS + 1);

  slot_e         st_q;
  logic [CW-1:0] dk_q, dk_nxt;
  logic          fin_q, memw_a_q;
  logic          start, mid, fin_set, wd_set;

  assign start    = (st_q == ST_IDLE) && ph_q && req_i;
  assign mid      = (st_q == ST_DATA) && !ph_q;
  assign fin_edge = (st_q == ST_DATA) && ph_q && fin_q;
  assign fin_set  = mid && (((dk_q >= CW'(2)) && (dk_q <= CW'(4)) && !zws_n_i) ||
                            ((dk_q >= CW'(5)) && rdy_i));
  assign wd_set   = mid && !fin_set && (dk_q == CW'(WD_DCLKS));
  assign d1_nxt   = (dk_nxt == CW'(1));

  always_comb begin
    st_nxt = st_q;
    dk_nxt = dk_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_nxt = ST_ADDR;
        dk_nxt = '0;
      end
      ST_ADDR: if (ph_q) begin
        st_nxt = ST_DATA;
        dk_nxt = CW'(1);
      end
      ST_DATA: if (ph_q) begin
        if (fin_q) begin
          st_nxt = ST_IDLE;
          dk_nxt = '0;
        end else begin
          dk_nxt = dk_q + CW'(1);
        end
      end
      default: begin
        st_nxt = ST_IDLE;
        dk_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dk_q     <= '0;
      fin_q    <= 1'b0;
      wd_q     <= 1'b0;
      wide_q   <= 1'b0;
      memw_a_q <= 1'b0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      io_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      st_q <= st_nxt;
      dk_q <= dk_nxt;
      if (start) begin
        addr_q  <= addr_i;
        wr_q    <= wr_i;
        io_q    <= io_i;
        wdata_q <= wdata_i;
        fin_q   <= 1'b0;
        wd_q    <= 1'b0;
        wide_q  <= 1'b0;
      end
      // first wide-memory sample: end of the address bus clock
      if ((st_q == ST_ADDR) && ph_q)
        memw_a_q <= !mem_wide_n_i;
      // second memory sample and the only I/O sample: middle of data clock 1
      if (mid && (dk_q == CW'(1)))
        wide_q <= io_q ? !io_wide_n_i : (memw_a_q && !mem_wide_n_i);
      if (fin_set || wd_set)
        fin_q <= 1'b1;
      if (wd_set)
        wd_q <= 1'b1;
    end
  end

  assert_no_short_end_R6: assert property (@(posedge clk) disable iff (rst)
    fin_edge |-> (dk_q >= CW'(2)));
  assert_wd_bound_R10: assert property (@(posedge clk) disable iff (rst)
    dk_q <= CW'(WD_DCLKS));
  assert_fields_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA) |-> $stable(addr_q));
endmodule

// File: rtl/isa8_busout.sv
module isa8_busout
  import isa8_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  slot_e         st_nxt,
  input  logic          ph_nxt,
  input  logic          d1_nxt,
  input  logic          fin_edge,
  input  logic          wd_q,
  input  logic          wide_q,
  input  logic [AW-1:0] addr_q,
  input  logic          wr_q,
  input  logic          io_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [DW-1:0] bdata_i,
  output logic          ale_o,
  output logic [AW-1:0] baddr_o,
  output logic [DW-1:0] bdata_o,
  output logic          bdata_oe_o,
  output logic [NCMD-1:0] cmd_n_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          wide_o
);
  logic a2_nxt, cmd_nxt, cmd_act;

  assign a2_nxt  = (st_nxt == ST_ADDR) && ph_nxt;
  assign cmd_nxt = (st_nxt == ST_DATA) && !(d1_nxt && !ph_nxt);
  assign cmd_act = !(&cmd_n_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o      <= 1'b0;
      baddr_o    <= '0;
      bdata_o    <= '0;
      bdata_oe_o <= 1'b0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      wide_o     <= 1'b0;
    end else begin
      ale_o  <= a2_nxt;
      done_o <= fin_edge;
      err_o  <= fin_edge && wd_q;
      wide_o <= fin_edge && wide_q;
      if (a2_nxt) begin
        baddr_o    <= addr_q;
        bdata_oe_o <= wr_q;
        if (wr_q)
          bdata_o <= wdata_q;
      end
      if (fin_edge && !wr_q && !wd_q)
        rdata_o <= bdata_i;
    end
  end

  for (genvar gi = 0; gi < NCMD; gi++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (rst)
        cmd_n_o[gi] <= 1'b1;
      else
        cmd_n_o[gi] <= !(cmd_nxt && (cmd_sel(io_q, wr_q) == 2'(gi)));
    end
  end

  assert_ale_half_R1: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> !ale_o);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_act && $past(cmd_act)) |-> $stable(baddr_o));
  assert_oe_drop_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bdata_oe_o) |-> ale_o);
  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(~cmd_n_o) <= 1);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cmd_act);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
endmodule

// File: rtl/isa8_cycle_ctl.sv
module isa8_cycle_ctl
  import isa8_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int WD_DCLKS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          io_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          wide_o,
  output logic          busclk_o,
  output logic          ale_o,
  output logic [AW-1:0] baddr_o,
  output logic [DW-1:0] bdata_o,
  output logic          bdata_oe_o,
  input  logic [DW-1:0] bdata_i,
  output logic          mem_rd_n_o,
  output logic          mem_wr_n_o,
  output logic          io_rd_n_o,
  output logic          io_wr_n_o,
  input  logic          mem_wide_n_i,
  input  logic          io_wide_n_i,
  input  logic          zws_n_i,
  input  logic          rdy_i
);
  logic            ph_q, ph_nxt, d1_nxt, fin_edge, wd_q, wide_q, wr_q, io_q;
  slot_e           st_nxt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [NCMD-1:0] cmd_n;

  isa8_halfclk u_half (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nxt(ph_nxt), .busclk_o(busclk_o)
  );

  isa8_seq #(.AW(AW), .DW(DW), .WD_DCLKS(WD_DCLKS)) u_seq (
    .clk(clk), .rst(rst), .ph_q(ph_q), .req_i(req_i), .addr_i(addr_i),
    .wr_i(wr_i), .io_i(io_i), .wdata_i(wdata_i), .zws_n_i(zws_n_i),
    .rdy_i(rdy_i), .mem_wide_n_i(mem_wide_n_i), .io_wide_n_i(io_wide_n_i),
    .st_nxt(st_nxt), .d1_nxt(d1_nxt), .fin_edge(fin_edge), .wd_q(wd_q),
    .wide_q(wide_q), .addr_q(addr_q), .wr_q(wr_q), .io_q(io_q), .wdata_q(wdata_q)
  );

  isa8_busout #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .ph_nxt(ph_nxt), .d1_nxt(d1_nxt),
    .fin_edge(fin_edge), .wd_q(wd_q), .wide_q(wide_q), .addr_q(addr_q),
    .wr_q(wr_q), .io_q(io_q), .wdata_q(wdata_q), .bdata_i(bdata_i),
    .ale_o(ale_o), .baddr_o(baddr_o), .bdata_o(bdata_o), .bdata_oe_o(bdata_oe_o),
    .cmd_n_o(cmd_n), .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
    .wide_o(wide_o)
  );

  assign mem_rd_n_o = cmd_n[0];
  assign mem_wr_n_o = cmd_n[1];
  assign io_rd_n_o  = cmd_n[2];
  assign io_wr_n_o  = cmd_n[3];
endmodule

// File: tb/sim_isa8_cycle_ctl.sv
module sim_isa8_cycle_ctl;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req = 0, wr = 0, io = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, bdi = '0;
  logic          mw_n = 1, iow_n = 1, zws_n = 1, rdy = 1;
  logic [DW-1:0] rdata, bdo;
  logic [AW-1:0] baddr;
  logic          done, err, wide, bclk, ale, oe, mrd_n, mwr_n, iord_n, iowr_n;

  isa8_cycle_ctl #(.AW(AW), .DW(DW), .WD_DCLKS(WD)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .wr_i(wr), .io_i(io),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .err_o(err), .wide_o(wide),
    .busclk_o(bclk), .ale_o(ale), .baddr_o(baddr), .bdata_o(bdo),
    .bdata_oe_o(oe), .bdata_i(bdi), .mem_rd_n_o(mrd_n), .mem_wr_n_o(mwr_n),
    .io_rd_n_o(iord_n), .io_wr_n_o(iowr_n), .mem_wide_n_i(mw_n),
    .io_wide_n_i(iow_n), .zws_n_i(zws_n), .rdy_i(rdy)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] prev_rd = '0;
  logic          prev_oe = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // last data clock index from the requirements
  function automatic int last_dk(int nw, int s);
    if (nw >= 2 && nw <= 4) return nw;          // R6
    if (5 + s > WD) return WD;                  // R10
    return 5 + s;                               // R7, R8
  endfunction

  function automatic bit wd_hit(int nw, int s);
    return !(nw >= 2 && nw <= 4) && (5 + s > WD);
  endfunction

  // mwm: 0 wide-mem high, 1 low at both samples, 2 low only at end of address clock
  task automatic run(input logic [AW-1:0] a, input logic w, input logic i,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                     input int nw, input int s, input int mwm, input logic iw_n);
    int k_end, guard;
    bit e, exp_wide, exp_low;
    k_end = last_dk(nw, s);
    e = wd_hit(nw, s);
    exp_wide = i ? !iw_n : (mwm == 1);
    @(negedge clk);
    req = 1; addr = a; wr = w; io = i; wdata = wd;
    bdi = ~rd; iow_n = iw_n; mw_n = (mwm == 0); zws_n = 1; rdy = 1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
      if (!ale) chk(oe == prev_oe, "R3", "oe before next ale", oe, prev_oe);
    end while (!ale && guard < 8);
    chk(ale, "R1", "ale seen", ale, 1);
    for (int j = 0; j <= 2 * k_end + 1; j++) begin
      if (j > 0) @(negedge clk);
      // checks for slot j (0 = second half of address clock)
      chk(ale == (j == 0), "R1", "ale", ale, j == 0);
      chk(bclk == (j % 2 == 1), "R1", "busclk", bclk, j % 2 == 1);
      exp_low = (j >= 2) && (j <= 2 * k_end);
      chk(mrd_n == !(exp_low && !i && !w), "R4", "mem rd strobe", mrd_n, !(exp_low && !i && !w));
      chk(mwr_n == !(exp_low && !i && w),  "R4", "mem wr strobe", mwr_n, !(exp_low && !i && w));
      chk(iord_n == !(exp_low && i && !w), "R4", "io rd strobe", iord_n, !(exp_low && i && !w));
      chk(iowr_n == !(exp_low && i && w),  "R4", "io wr strobe", iowr_n, !(exp_low && i && w));
      if (j <= 2 * k_end) chk(baddr == a, "R2", "bus address", baddr, a);
      chk(oe == w, "R3", "data enable", oe, w);
      if (w) chk(bdo == wd, "R3", "write data", bdo, wd);
      chk(done == (j == 2 * k_end + 1), "R9", "done", done, j == 2 * k_end + 1);
      chk(err == (e && j == 2 * k_end + 1), "R10", "err", err, e && j == 2 * k_end + 1);
      if (j == 2 * k_end + 1) begin
        chk(wide == exp_wide, "R5", "wide flag", wide, exp_wide);
        if (!w && !e) prev_rd = rd;
        chk(rdata == prev_rd, "R9", "read data", rdata, prev_rd);
      end
      // drive inputs for the edge ending slot j
      mw_n = (mwm == 1) ? 1'b0 : (mwm == 2) ? (j != 0) : 1'b1;
      zws_n = !(nw > 0 && j == 2 * nw - 1);
      if (j % 2 == 1) rdy = !(((j + 1) / 2) >= 5 && ((j + 1) / 2) <= 4 + s);
      else rdy = 1'b0;
      bdi = (j == 2 * k_end) ? rd : ~rd;
      if (j == 2 * k_end + 1) begin
        req = 0; rdy = 1; zws_n = 1; mw_n = 1; iow_n = 1;
      end
    end
    prev_oe = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(mrd_n & mwr_n & iord_n & iowr_n, "R11", "strobes in reset", {mrd_n, mwr_n, iord_n, iowr_n}, 4'hf);
    chk(!ale && !oe && !done && !err, "R11", "flags in reset", {ale, oe, done, err}, 0);
    chk(rdata == 0, "R11", "rdata in reset", rdata, 0);
    rst = 0;
    // directed corners
    run(20'h12345, 0, 0, 8'h00, 8'h5a, 0, 0, 0, 1);   // R7 default read
    run(20'h00f0f, 1, 1, 8'hc3, 8'h11, 2, 0, 0, 1);   // R6 3 BCLK
    run(20'h0abcd, 0, 1, 8'h00, 8'h22, 3, 0, 0, 1);   // R6 4 BCLK, R3 oe drop
    run(20'hfffff, 1, 0, 8'h3c, 8'h33, 4, 0, 0, 1);   // R6 5 BCLK
    run(20'h00001, 0, 0, 8'h00, 8'h44, 1, 0, 0, 1);   // R6 data clock 1 ignored
    run(20'h55555, 0, 1, 8'h00, 8'h66, 5, 2, 0, 1);   // R8 zws ignored in stretch
    run(20'h2aaaa, 0, 0, 8'h00, 8'h77, 0, 11, 0, 1);  // R8/R10 ends exactly at limit
    run(20'h31337, 0, 0, 8'h00, 8'h88, 0, 12, 0, 1);  // R10 watchdog
    run(20'h31338, 1, 0, 8'h99, 8'h99, 0, 20, 0, 1);  // R10 watchdog on write
    run(20'h40000, 0, 0, 8'h00, 8'haa, 0, 0, 2, 1);   // R5 one sample only
    run(20'h40001, 0, 0, 8'h00, 8'hbb, 0, 0, 1, 1);   // R5 wide memory
    run(20'h00300, 1, 1, 8'h5e, 8'hcc, 0, 1, 0, 0);   // R5 wide io
    // constrained random mix
    for (int n = 0; n < 150; n++) begin
      int nw, s, m;
      nw = $urandom_range(0, 5);
      s = ($urandom_range(0, 9) == 0) ? $urandom_range(11, 14) : $urandom_range(0, 3);
      m = $urandom_range(0, 2);
      run(AW'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
          nw, s, m, 1'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule